// File: doc/BRIEF.md
# Ahead-Pipelined Conditional Branch Direction Predictor

This block predicts taken or not-taken for one fetch block per cycle. It starts the table read well before the prediction is needed. When a fetch block enters, its address and the current global history form a base index for each of four counter banks. The next three fetch blocks then each fold one address bit into every bank index. Each bank takes a different bit of the same block, and each pipeline step writes it to a different index position. The last of those steps also reads the banks. A final stage then combines the four counters into one direction. No single cycle holds both the index computation and a full table read.

The banks are a bimodal bank, two history-hashed banks and a chooser bank. Each holds 2-bit saturating counters. The direction is the bimodal counter's upper bit, unless the chooser counter's upper bit is set, in which case the majority of the three direction banks decides. Every prediction reports the four indices and the four counters it read. The pipeline owner keeps these as a checkpoint and hands them back with the resolved outcome on the update port. A flush clears every block in flight and loads the history register from a value supplied with the flush.

Top module: `apcp_predictor`

## Requirements
- R1: While `rst` is high, and for exactly 1024 cycles after it falls (2^IW), `ready` is low, no request is accepted and `pred_valid` is low. In that time every counter of every bank is set to 01 (weakly not-taken), so a fresh entry reads as `pred_ctr` = 8'h55.
- R2: A request accepted in cycle t, with no flush in cycles t..t+4, gives exactly one `pred_valid` pulse, in cycle t+5. Predictions come out in request order.
- R3: Let f be the XOR of the request address split into IW-bit chunks (the top chunk zero-extended), and h the history register in cycle t. The base index is f for bank 0 (bimodal). For bank b = 1, 2, 3 it is f XOR (h rotated left by 3*(b-1)).
- R4: For j = 1, 2, 3, a valid request in cycle t+j whose address bit b is 1 inverts bit IW-j of bank b's index for the request of cycle t.
- R5: `pred_idx[b*IW +: IW]` is the index bank b was read at. `pred_ctr[2b+1:2b]` is the counter read there. The bank order is 0 bimodal, 1 and 2 history banks, 3 chooser.
- R6: `pred_taken` is the majority of the upper bits of banks 0 to 2 when the chooser's upper bit is 1, and otherwise the upper bit of bank 0.
- R7: At the edge that raises `pred_valid`, the history register shifts left and takes `pred_taken` into bit 0. Requests issued afterwards see the new history.
- R8: On update, the chooser counter is written only when the bimodal bit and the vote differ in `upd_ctr`. It moves up when the vote equals `upd_taken`, and down otherwise.
- R9: On update, if the final direction derived from `upd_ctr` differs from `upd_taken`, all three direction banks move toward `upd_taken`.
- R10: On update, if the final direction is correct, only the direction banks whose upper bit equals `upd_taken` are written (toward `upd_taken`). The other banks keep their stored value.
- R11: Counter updates saturate at 00 and 11.
- R12: A flush drops every request in flight, including one presented in the flush cycle. No `pred_valid` follows for them, and the history register becomes `flush_hist`.
- R13: When an update writes an entry in the same cycle that a bank reads it, the prediction reports the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the counter clear |
| ready | output | 1 | High once the counter clear has finished |
| req_valid | input | 1 | A fetch block enters the pipeline this cycle |
| req_addr | input | AW | Fetch block address |
| flush | input | 1 | Drop all blocks in flight and restore the history |
| flush_hist | input | IW | History value loaded on flush |
| pred_valid | output | 1 | Prediction available this cycle |
| pred_taken | output | 1 | Predicted direction |
| pred_idx | output | 4*IW | Indices read, bank b at [b*IW +: IW] |
| pred_ctr | output | 8 | Counters read, bank b at [2b+1:2b] |
| upd_valid | input | 1 | Resolved outcome present |
| upd_idx | input | 4*IW | Checkpointed indices of the resolved block |
| upd_ctr | input | 8 | Checkpointed counters of the resolved block |
| upd_taken | input | 1 | Resolved direction |

## Verification
An update can write an entry in the same cycle that the pipeline's read stage fetches it. The bench provokes this with a directed case: it issues a request, and three cycles later it writes that request's own entry through the update port. The prediction must show the pre-write counters, and a later request to the same entry must show the trained ones. In the random phase, requests, flushes and updates overlap freely, with updates often aimed at entries just read. A cycle-level reference model built from the requirements judges every prediction, including the read-before-write ordering.

// File: rtl/apcp_pkg.sv
package apcp_pkg;
  localparam int NBANK = 4;
  localparam int BIM   = 0;
  localparam int HB0   = 1;
  localparam int HB1   = 2;
  localparam int META  = 3;

  function automatic logic [1:0] sat2(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/apcp_bank.sv
module apcp_bank #(
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic [IW-1:0] rd_addr,
  output logic [1:0]    rd_data,
  input  logic          we,
  input  logic [IW-1:0] wr_addr,
  input  logic [1:0]    wr_data
);
  localparam int DEPTH = 1 << IW;

  logic [1:0] mem [0:DEPTH-1];

  // read-first single-clock RAM: a same-cycle write is not seen by the read
  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/apcp_path.sv
module apcp_path
  import apcp_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic                      acc,
  input  logic [AW-1:0]             addr,
  input  logic [IW-1:0]             hist,
  output logic [NBANK-1:0][IW-1:0]  rd_idx,
  output logic                      v4,
  output logic [NBANK-1:0][IW-1:0]  idx4
);
  localparam int NCH   = (AW + IW - 1) / IW;
  localparam int HSTEP = 3;

  function automatic logic [IW-1:0] fold(input logic [AW-1:0] a);
    logic [NCH*IW-1:0] e;
    logic [IW-1:0]     r;
    e = (NCH*IW)'(a);
    r = '0;
    for (int k = 0; k < NCH; k++) r ^= e[k*IW +: IW];
    return r;
  endfunction

  function automatic logic [IW-1:0] rotl(input logic [IW-1:0] v, input int n);
    logic [2*IW-1:0] d;
    d = {v, v} << (n % IW);
    return d[2*IW-1:IW];
  endfunction

  function automatic logic [IW-1:0] flip(input logic [IW-1:0] v, input int pos, input logic b);
    logic [IW-1:0] r;
    r = v;
    r[pos] = r[pos] ^ b;
    return r;
  endfunction

  logic                     v1, v2, v3;
  logic [NBANK-1:0][IW-1:0] i1, i2, i3;
  logic [NBANK-1:0][IW-1:0] base, n2, n3;
  logic [NBANK-1:0]         pb;
  logic [IW-1:0]            fa;

  assign fa = fold(addr);
  assign pb = {NBANK{acc}} & addr[NBANK-1:0];

  for (genvar b = 0; b < NBANK; b++) begin : g_idx
    if (b == BIM) begin : g_bim
      assign base[b] = fa;
    end else begin : g_hist
      assign base[b] = fa ^ rotl(hist, HSTEP * (b - 1));
    end
    assign n2[b]     = flip(i1[b], IW - 1, pb[b]);
    assign n3[b]     = flip(i2[b], IW - 2, pb[b]);
    assign rd_idx[b] = flip(i3[b], IW - 3, pb[b]);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      v4 <= 1'b0;
    end else begin
      v1 <= acc;
      v2 <= v1;
      v3 <= v2;
      v4 <= v3;
    end
    i1   <= base;
    i2   <= n2;
    i3   <= n3;
    idx4 <= rd_idx;
  end

  // R2
  stage_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (v3 && !flush) |=> v4);
endmodule

// File: rtl/apcp_train.sv
module apcp_train
  import apcp_pkg::*;
(
  input  logic                  upd_valid,
  input  logic [NBANK-1:0][1:0] ctr,
  input  logic                  taken,
  output logic [NBANK-1:0]      we,
  output logic [NBANK-1:0][1:0] wd
);
  logic bim, vote, fin, miss;

  assign bim  = ctr[BIM][1];
  assign vote = maj3(ctr[BIM][1], ctr[HB0][1], ctr[HB1][1]);
  assign fin  = ctr[META][1] ? vote : bim;
  assign miss = fin != taken;

  for (genvar b = 0; b < NBANK; b++) begin : g_tr
    if (b == META) begin : g_meta
      assign we[b] = upd_valid && (bim != vote);
      assign wd[b] = sat2(ctr[b], vote == taken);
    end else begin : g_dir
      assign we[b] = upd_valid && (miss || (ctr[b][1] == taken));
      assign wd[b] = sat2(ctr[b], taken);
    end
  end
endmodule

// File: rtl/apcp_predictor.sv
module apcp_predictor
  import apcp_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic                  ready,
  input  logic                  req_valid,
  input  logic [AW-1:0]         req_addr,
  input  logic                  flush,
  input  logic [IW-1:0]         flush_hist,
  output logic                  pred_valid,
  output logic                  pred_taken,
  output logic [NBANK*IW-1:0]   pred_idx,
  output logic [2*NBANK-1:0]    pred_ctr,
  input  logic                  upd_valid,
  input  logic [NBANK*IW-1:0]   upd_idx,
  input  logic [2*NBANK-1:0]    upd_ctr,
  input  logic                  upd_taken
);
  logic [IW:0]              clr_cnt;
  logic [IW-1:0]            ghist;
  logic [NBANK-1:0][IW-1:0] rd_idx, idx4, uidx;
  logic [NBANK-1:0][1:0]    q, uctr, twd, bwd;
  logic [NBANK-1:0][IW-1:0] bwa;
  logic [NBANK-1:0]         twe, bwe;
  logic                     v4, dir;

  assign ready = clr_cnt[IW];
  assign uidx  = upd_idx;
  assign uctr  = upd_ctr;

  always_ff @(posedge clk) begin
    if (rst) clr_cnt <= '0;
    else if (!clr_cnt[IW]) clr_cnt <= clr_cnt + 1'b1;
  end

  apcp_path #(.AW(AW), .IW(IW)) u_path (
    .clk(clk), .rst(rst), .flush(flush), .acc(req_valid && ready),
    .addr(req_addr), .hist(ghist), .rd_idx(rd_idx), .v4(v4), .idx4(idx4)
  );

  apcp_train u_train (
    .upd_valid(upd_valid && ready), .ctr(uctr), .taken(upd_taken),
    .we(twe), .wd(twd)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bwe[b] = !ready || twe[b];
    assign bwa[b] = ready ? uidx[b] : clr_cnt[IW-1:0];
    assign bwd[b] = ready ? twd[b] : 2'b01;
    apcp_bank #(.IW(IW)) u_bank (
      .clk(clk), .rd_addr(rd_idx[b]), .rd_data(q[b]),
      .we(bwe[b]), .wr_addr(bwa[b]), .wr_data(bwd[b])
    );
  end

  assign dir = q[META][1] ? maj3(q[BIM][1], q[HB0][1], q[HB1][1]) : q[BIM][1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_idx   <= '0;
      pred_ctr   <= '0;
      ghist      <= '0;
    end else if (flush) begin
      pred_valid <= 1'b0;
      ghist      <= flush_hist;
    end else begin
      pred_valid <= v4;
      if (v4) begin
        pred_taken <= dir;
        pred_idx   <= idx4;
        pred_ctr   <= q;
        ghist      <= {ghist[IW-2:0], dir};
      end
    end
  end

  // R1
  busy_no_pred_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !pred_valid);
  // R12
  flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pred_valid);
  // R7
  hist_tail_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> (ghist[0] == pred_taken));
  // R8
  meta_train_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && bwe[META]) |->
      (upd_valid && (uctr[BIM][1] != maj3(uctr[BIM][1], uctr[HB0][1], uctr[HB1][1]))));
endmodule

// File: tb/apcp_predictor_test.sv
module apcp_predictor_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 16;
  localparam int IW = 10;
  localparam int NB = 4;
  localparam int DEPTH = 1 << IW;

  logic clk = 1'b0;
  logic rst;
  logic ready;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic flush;
  logic [IW-1:0] flush_hist;
  logic pred_valid, pred_taken;
  logic [NB*IW-1:0] pred_idx;
  logic [2*NB-1:0] pred_ctr;
  logic upd_valid;
  logic [NB*IW-1:0] upd_idx;
  logic [2*NB-1:0] upd_ctr;
  logic upd_taken;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  apcp_predictor #(.AW(AW), .IW(IW)) uut (
    .clk(clk), .rst(rst), .ready(ready), .req_valid(req_valid), .req_addr(req_addr),
    .flush(flush), .flush_hist(flush_hist), .pred_valid(pred_valid), .pred_taken(pred_taken),
    .pred_idx(pred_idx), .pred_ctr(pred_ctr), .upd_valid(upd_valid), .upd_idx(upd_idx),
    .upd_ctr(upd_ctr), .upd_taken(upd_taken)
  );

  // reference model state
  logic mv1, mv2, mv3, mv4;
  logic [IW-1:0] mi1 [NB];
  logic [IW-1:0] mi2 [NB];
  logic [IW-1:0] mi3 [NB];
  logic [IW-1:0] mi4 [NB];
  logic [1:0] mq [NB];
  logic [1:0] mm [NB][DEPTH];
  logic [IW-1:0] mh;
  logic ev, et;
  logic [NB*IW-1:0] eidx;
  logic [2*NB-1:0] ectr;
  logic [NB*IW-1:0] last_idx;
  logic [2*NB-1:0] last_ctr;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] rot(input logic [IW-1:0] v, input int n);
    logic [IW-1:0] r;
    for (int i = 0; i < IW; i++) r[(i + n) % IW] = v[i];
    return r;
  endfunction

  function automatic logic [IW-1:0] hsh(input int b, input logic [AW-1:0] a, input logic [IW-1:0] h);
    logic [IW-1:0] f;
    f = a[IW-1:0] ^ {{(2*IW-AW){1'b0}}, a[AW-1:IW]};
    return (b == 0) ? f : f ^ rot(h, 3 * (b - 1));
  endfunction

  function automatic logic [1:0] step(input logic [1:0] c, input logic up);
    int v;
    v = up ? int'(c) + 1 : int'(c) - 1;
    if (v > 3) v = 3;
    if (v < 0) v = 0;
    return v[1:0];
  endfunction

  function automatic logic dirf(input logic [7:0] c);
    int n;
    n = int'(c[1]) + int'(c[3]) + int'(c[5]);
    return c[7] ? (n >= 2) : c[1];
  endfunction

  task automatic train(input logic [NB*IW-1:0] ix, input logic [7:0] c, input logic t);
    logic bm, vt, fin;
    int n;
    bm = c[1];
    n = int'(c[1]) + int'(c[3]) + int'(c[5]);
    vt = (n >= 2);
    fin = c[7] ? vt : bm;
    for (int b = 0; b < 3; b++)
      if (fin != t || c[2*b+1] == t) mm[b][ix[b*IW +: IW]] = step(c[2*b +: 2], t);
    if (bm != vt) mm[3][ix[3*IW +: IW]] = step(c[7:6], vt == t);
  endtask

  task automatic model_edge();
    logic [IW-1:0] n1 [NB];
    logic [IW-1:0] n2 [NB];
    logic [IW-1:0] n3 [NB];
    logic [IW-1:0] rd [NB];
    logic [1:0] qn [NB];
    logic [7:0] qv;
    logic pb, d;
    for (int b = 0; b < NB; b++) begin
      pb = req_valid & req_addr[b];
      n1[b] = hsh(b, req_addr, mh);
      n2[b] = mi1[b]; n2[b][IW-1] = n2[b][IW-1] ^ pb;
      n3[b] = mi2[b]; n3[b][IW-2] = n3[b][IW-2] ^ pb;
      rd[b] = mi3[b]; rd[b][IW-3] = rd[b][IW-3] ^ pb;
      qn[b] = mm[b][rd[b]];
    end
    qv = {mq[3], mq[2], mq[1], mq[0]};
    if (flush) begin
      ev = 1'b0;
      mh = flush_hist;
    end else begin
      ev = mv4;
      if (mv4) begin
        d = dirf(qv);
        et = d;
        eidx = {mi4[3], mi4[2], mi4[1], mi4[0]};
        ectr = qv;
        mh = {mh[IW-2:0], d};
      end
    end
    if (flush) begin
      mv1 = 0; mv2 = 0; mv3 = 0; mv4 = 0;
    end else begin
      mv4 = mv3; mv3 = mv2; mv2 = mv1; mv1 = req_valid;
    end
    for (int b = 0; b < NB; b++) begin
      mi1[b] = n1[b]; mi2[b] = n2[b]; mi3[b] = n3[b]; mi4[b] = rd[b]; mq[b] = qn[b];
    end
    if (upd_valid) train(upd_idx, upd_ctr, upd_taken);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(pred_valid === ev, "R2 valid", 64'(pred_valid), 64'(ev));
    if (ev) begin
      chk(pred_taken === et, "R6 direction", 64'(pred_taken), 64'(et));
      chk(pred_idx === eidx, "R3 R4 R7 index", 64'(pred_idx), 64'(eidx));
      chk(pred_ctr === ectr, "R5 R8 R9 R10 R11 R13 counters", 64'(pred_ctr), 64'(ectr));
    end
    if (pred_valid) begin
      last_idx = pred_idx;
      last_ctr = pred_ctr;
    end
  endtask

  task automatic flush_to(input logic [IW-1:0] h);
    flush = 1'b1; flush_hist = h;
    tick();
    flush = 1'b0;
  endtask

  task automatic upd(input logic [IW-1:0] i, input logic [7:0] c, input logic t);
    upd_valid = 1'b1; upd_idx = {NB{i}}; upd_ctr = c; upd_taken = t;
    tick();
    upd_valid = 1'b0;
  endtask

  task automatic issue(input logic [AW-1:0] a, output logic [NB*IW-1:0] oi,
                       output logic [7:0] oc, output logic ot);
    int n;
    req_valid = 1'b1; req_addr = a;
    tick();
    req_valid = 1'b0;
    n = 1;
    while (!pred_valid && n < 10) begin
      tick();
      n++;
    end
    chk(n == 5, "R2 latency", 64'(n), 64'd5);
    oi = pred_idx; oc = pred_ctr; ot = pred_taken;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NB*IW-1:0] oi;
    logic [7:0] oc;
    logic ot;
    bit quiet;
    int n;
    rst = 1'b1; req_valid = 0; req_addr = '0; flush = 0; flush_hist = '0;
    upd_valid = 0; upd_idx = '0; upd_ctr = '0; upd_taken = 0;
    last_idx = '0; last_ctr = 8'h55;
    void'($urandom(32'h5eed_c0de));
    repeat (5) @(negedge clk);
    chk(!ready && !pred_valid, "R1 reset state", {62'd0, ready, pred_valid}, 64'd0);
    rst = 1'b0;
    n = 0;
    while (!ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(n == DEPTH, "R1 clear length", 64'(n), 64'(DEPTH));

    mv1 = 0; mv2 = 0; mv3 = 0; mv4 = 0; mh = '0; ev = 0; et = 0; eidx = '0; ectr = '0;
    for (int b = 0; b < NB; b++) begin
      mi1[b] = '0; mi2[b] = '0; mi3[b] = '0; mi4[b] = '0; mq[b] = '0;
      for (int e = 0; e < DEPTH; e++) mm[b][e] = 2'b01;
    end

    // R1 R3: fresh entry, zero history
    flush_to('0);
    issue(16'h0005, oi, oc, ot);
    chk(oc == 8'h55, "R1 fresh counters", 64'(oc), 64'h55);
    chk(oi == {NB{10'd5}}, "R3 base index", 64'(oi), 64'(NB*IW)'({NB{10'd5}}));
    chk(ot == 1'b0, "R6 weak not-taken", 64'(ot), 64'd0);

    // R9: mispredict trains all direction banks, chooser left alone
    upd(10'd5, 8'h55, 1'b1);
    flush_to('0);
    issue(16'h0005, oi, oc, ot);
    chk(oc == 8'h6A, "R9 mispredict update", 64'(oc), 64'h6A);
    chk(ot == 1'b1, "R6 bimodal decides", 64'(ot), 64'd1);

    // R10: correct, all agree, strengthen
    upd(10'd5, 8'h6A, 1'b1);
    flush_to('0);
    issue(16'h0005, oi, oc, ot);
    chk(oc == 8'h7F, "R10 strengthen", 64'(oc), 64'h7F);

    // R11: saturation high and low
    upd(10'd5, 8'h7F, 1'b1);
    upd(10'd10, 8'h40, 1'b0);
    flush_to('0);
    issue(16'h0005, oi, oc, ot);
    chk(oc == 8'h7F, "R11 saturate high", 64'(oc), 64'h7F);
    flush_to('0);
    issue(16'h000A, oi, oc, ot);
    chk(oc == 8'h40, "R11 saturate low", 64'(oc), 64'h40);

    // R10: disagreeing bank not written
    upd(10'd6, 8'h73, 1'b1);
    flush_to('0);
    issue(16'h0006, oi, oc, ot);
    chk(oc == 8'h77, "R10 partial update", 64'(oc), 64'h77);

    // R8: chooser trained on disagreement
    upd(10'd7, 8'h83, 1'b0);
    flush_to('0);
    issue(16'h0007, oi, oc, ot);
    chk(oc == 8'hC1, "R8 chooser train", 64'(oc), 64'hC1);
    chk(ot == 1'b0, "R6 vote not-taken", 64'(ot), 64'd0);

    // R6: vote overrides bimodal
    upd(10'd11, 8'hFC, 1'b1);
    flush_to('0);
    issue(16'h000B, oi, oc, ot);
    chk(oc == 8'hFD, "R8 R10 vote entry", 64'(oc), 64'hFD);
    chk(ot == 1'b1, "R6 vote overrides", 64'(ot), 64'd1);

    // R7: history takes the prediction
    flush_to('0);
    issue(16'h0005, oi, oc, ot);
    issue(16'h0000, oi, oc, ot);
    chk(oi[IW +: IW] == 10'd1, "R7 history shift", 64'(oi[IW +: IW]), 64'd1);

    // R13: update and read of one entry in the same cycle
    flush_to('0);
    req_valid = 1'b1; req_addr = 16'h0009;
    tick();
    req_valid = 1'b0;
    tick();
    tick();
    upd_valid = 1'b1; upd_idx = {NB{10'd9}}; upd_ctr = 8'h55; upd_taken = 1'b1;
    tick();
    upd_valid = 1'b0;
    tick();
    chk(pred_valid && pred_ctr == 8'h55, "R13 read before write", 64'(pred_ctr), 64'h55);
    flush_to('0);
    issue(16'h0009, oi, oc, ot);
    chk(oc == 8'h6A, "R13 write landed", 64'(oc), 64'h6A);

    // R4: in-flight path bits
    flush_to('0);
    req_valid = 1'b1; req_addr = 16'h0000;
    tick();
    req_addr = 16'h000F;
    tick(); tick(); tick();
    req_valid = 1'b0;
    tick();
    chk(pred_valid && pred_idx == {NB{10'h380}}, "R4 path bits", 64'(pred_idx),
        64'(NB*IW)'({NB{10'h380}}));
    repeat (8) tick();

    // R12: flush drops in-flight block and restores history
    flush_to('0);
    req_valid = 1'b1; req_addr = 16'h0033;
    tick();
    req_valid = 1'b0;
    tick();
    req_valid = 1'b1; req_addr = 16'h0044;
    flush = 1'b1; flush_hist = 10'h2A5;
    tick();
    flush = 1'b0; req_valid = 1'b0;
    quiet = 1'b1;
    for (int k = 0; k < 7; k++) begin
      tick();
      if (pred_valid) quiet = 1'b0;
    end
    chk(quiet, "R12 in-flight dropped", 64'(!quiet), 64'd0);
    issue(16'h0000, oi, oc, ot);
    chk(oi[IW +: IW] == 10'h2A5, "R12 history restore", 64'(oi[IW +: IW]), 64'h2A5);

    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      req_valid = ($urandom % 10) < 7;
      req_addr = AW'($urandom);
      flush = ($urandom % 60) == 0;
      flush_hist = IW'($urandom);
      upd_valid = ($urandom % 10) < 4;
      if ($urandom % 2) begin
        upd_idx = last_idx; upd_ctr = last_ctr;
      end else begin
        upd_idx = {NB{IW'($urandom)}} ^ (NB*IW)'($urandom);
        upd_ctr = 8'($urandom);
      end
      upd_taken = $urandom % 2;
      tick();
    end
    req_valid = 0; flush = 0; upd_valid = 0;
    repeat (10) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule